// File: doc/BRIEF.md
# MDIO Management Master

This block lets software read and write the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface, using IEEE 802.3 clause-22 frames. Software sees two 32-bit registers, selected by a one-bit address. One is a command register and the other is a data register.

Software launches a transaction with a single write to the command register. That word gives the PHY address, the register number and a direction flag. For a write, software first places the 16-bit value in the data register. While the frame is on the wire, a busy flag in the command register reads 1, and software polls it to find out when the transaction has finished. When a read ends, the value taken from the PHY appears in the data register.

The block derives MDC from the system clock with a parameterised divider. It drives MDIO only while MDC is low. On reads it releases MDIO at the turnaround.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command register reads 0, the data register reads 0, and both MDC and the MDIO output enable are low.
- R2: A command write with bit 10 = 0 starts a read frame, sent MSB first: 32 ones, start `01`, opcode `10`, the PHY address (command bits 9:5), then the register number (command bits 4:0).
- R3: A command write with bit 10 = 1 starts a write frame. It carries the same preamble and start, opcode `01`, the address fields, turnaround `10`, and then the 16 data-register bits MSB first.
- R4: Command bit 31 (busy) reads 1 from the cycle after a launching write until the frame completes, and reads 0 afterwards. Busy rises only after a command write.
- R5: During a read frame, the MDIO output enable is high for the first 46 bits and low from the turnaround (bit index 46) through the end of the frame. During a write frame it is high for all 64 bits.
- R6: A read samples MDIO on the MDC rising edges of the 16 data bits, MSB first. Once busy drops, the data register reads {16'h0, value}.
- R7: While a frame is active, MDC has a period of 2*HALF_DIV system clocks. Each frame has exactly 64 MDC rising edges, and MDC stays low while idle.
- R8: MDIO output and output enable change only on the clock edge where MDC falls, or at launch while MDC is low. They never change while MDC is high.
- R9: A command write while busy is ignored. The running frame, the command fields read back and the number of frames are all unchanged.
- R10: A data-register write loads the 16 write-data bits. The data register's upper 16 bits always read 0, and a write frame leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 command, 1 data |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
The hardest case to reach is a command write that arrives while a frame is in progress. It must leave both the wire and the readback untouched. The bench launches a read and, partway through, issues a conflicting write command. It then checks three things: the captured header still matches the first command, the frame contains exactly 64 MDC edges, and no second frame starts. The read-capture path relies on a bench PHY model that drives each data bit after the preceding falling MDC edge. This model is swept over every PHY address, so every bit position of the address and register fields gets exercised.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared frame constants, the command type and the frame builder
// for the MDIO management master. Assumes clause-22 frames of 64 bits.
package mdio_pkg;
    localparam int          FRAME_W  = 64;
    localparam logic [5:0]  TA_IDX   = 6'd46;
    localparam logic [5:0]  DATA_IDX = 6'd48;
    localparam logic [5:0]  LAST_IDX = 6'd63;
    localparam logic        SEL_CTRL = 1'b0;
    localparam logic        SEL_DATA = 1'b1;

    typedef struct packed {
        logic       wr;
        logic [4:0] phy;
        logic [4:0] regn;
    } mdio_cmd_t;

    // Assemble the full serial frame, MSB sent first.
    function automatic logic [FRAME_W-1:0] build_frame(mdio_cmd_t c, logic [15:0] wd);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dat;
        op  = c.wr ? 2'b01 : 2'b10;
        ta  = c.wr ? 2'b10 : 2'b11;
        dat = c.wr ? wd : 16'hFFFF;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, ta, dat};
    endfunction
endpackage

// File: rtl/mdc_gen.sv
`timescale 1ns/1ps
// mdc_gen: divides the system clock into MDC while run is high.
// Gives one-cycle strobes on the cycle before each MDC edge, so that
// logic clocked by clk acts exactly on the edge. MDC is held low when idle.
module mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == LAST);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    // Count half periods and toggle MDC at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
// mdio_shifter: serialises one frame and, on reads, captures the reply.
// Assumes start is asserted only while not active. Bits advance on the
// MDC falling strobe; read data is shifted in on the rising strobe.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        active,
    output logic        rd_mode,
    output logic [5:0]  bit_idx,
    output logic        rd_done,
    output logic [15:0] rd_value,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [FRAME_W-1:0] shreg;

    assign mdio_o  = shreg[FRAME_W-1];
    assign mdio_oe = active && !(rd_mode && (bit_idx >= TA_IDX));

    // Frame sequencing: load, shift on falling strobe, capture on rising.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            active   <= 1'b0;
            rd_mode  <= 1'b0;
            bit_idx  <= '0;
            rd_done  <= 1'b0;
            rd_value <= '0;
        end else begin
            rd_done <= 1'b0;
            if (start && !active) begin
                shreg   <= build_frame(cmd, wdata);
                active  <= 1'b1;
                rd_mode <= !cmd.wr;
                bit_idx <= '0;
            end else if (active) begin
                if (rise_stb && rd_mode && (bit_idx >= DATA_IDX)) begin
                    rd_value <= {rd_value[14:0], mdio_i};
                end
                if (fall_stb) begin
                    if (bit_idx == LAST_IDX) begin
                        active  <= 1'b0;
                        rd_done <= rd_mode;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[FRAME_W-2:0], 1'b1};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
// mdio_regs: command and data registers seen by software.
// Assumes a read result (rd_done) and a software data write never coincide;
// if they do, the read result wins.
module mdio_regs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_wen,
    input  logic [15:0] bus_wdata,
    input  logic        busy,
    input  logic        rd_done,
    input  logic [15:0] rd_value,
    output logic        start,
    output mdio_cmd_t   cmd_in,
    output mdio_cmd_t   cmd_q,
    output logic [15:0] data_q,
    output logic [31:0] bus_rdata
);
    assign cmd_in = mdio_cmd_t'(bus_wdata[10:0]);
    assign start  = bus_wen && (bus_addr == SEL_CTRL) && !busy;

    // Latch the command fields only when a transaction launches.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_q <= '0;
        else if (start) cmd_q <= cmd_in;
    end

    // Data register: read results first, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 data_q <= '0;
        else if (rd_done)                           data_q <= rd_value;
        else if (bus_wen && bus_addr == SEL_DATA)   data_q <= bus_wdata;
    end

    // Read mux for the two software-visible registers.
    always_comb begin
        if (bus_addr == SEL_CTRL) bus_rdata = {busy, 20'd0, cmd_q};
        else                      bus_rdata = {16'd0, data_q};
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// mdio_master: top of the MDIO management master. It joins the register
// file, the MDC divider and the frame shifter. Busy is the shifter's
// active flag. HALF_DIV is the number of system clocks per MDC half period.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_wen,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        busy;
    logic        start;
    logic        rise_stb;
    logic        fall_stb;
    logic        rd_mode;
    logic        rd_done;
    logic [5:0]  bit_idx;
    logic [15:0] rd_value;
    logic [15:0] data_q;
    mdio_cmd_t   cmd_in;
    mdio_cmd_t   cmd_q;

    mdio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .busy(busy), .rd_done(rd_done),
        .rd_value(rd_value), .start(start), .cmd_in(cmd_in), .cmd_q(cmd_q),
        .data_q(data_q), .bus_rdata(bus_rdata)
    );

    mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_in),
        .wdata(data_q), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .mdio_i(mdio_i), .active(busy), .rd_mode(rd_mode),
        .bit_idx(bit_idx), .rd_done(rd_done), .rd_value(rd_value),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
// mdio_master_chk: temporal properties of the management master, bound
// into every instance of mdio_master.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_addr,
    input logic        bus_wen,
    input logic        busy,
    input logic        rd_mode,
    input logic [5:0]  bit_idx,
    input logic [10:0] cmd_q,
    input logic [31:0] bus_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R7
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R8
    mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R4
    busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wen && (bus_addr == 1'b0)));

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_mode && (bit_idx >= 6'd46)) |-> !mdio_oe);

    // R1
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_q));

    // R10
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b1) |-> (bus_rdata[31:16] == 16'd0));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .busy(busy), .rd_mode(rd_mode), .bit_idx(bit_idx), .cmd_q(cmd_q),
    .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
// mdio_master_bench: sweeps reads and writes over all PHY addresses, with a
// PHY model that records each frame and answers reads.
module mdio_master_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wen = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int          total = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    int          pos = 0;
    logic [15:0] phy_val = '0;
    time         last_rise = 0;
    time         rise_dt = 0;
    int          r8_viol = 0;
    logic        prev_mdio = 1'b0;
    logic        prev_oe = 1'b0;

    mdio_master #(.HALF_DIV(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    // PHY model: record line state on each MDC rise
    always @(posedge mdc) begin
        cap_bits  = {cap_bits[62:0], mdio_o};
        cap_oe    = {cap_oe[62:0], mdio_oe};
        pos       = pos + 1;
        rise_dt   = $time - last_rise;
        last_rise = $time;
    end

    // PHY model: present reply bits after the falling edge
    always @(negedge mdc) begin
        if (pos >= 48 && pos <= 63) mdio_i = phy_val[63 - pos];
    end

    // R8 monitor: no MDIO change while MDC is high
    always @(negedge clk) begin
        if (rst_n && mdc && ((mdio_o !== prev_mdio) || (mdio_oe !== prev_oe)))
            r8_viol = r8_viol + 1;
        prev_mdio = mdio_o;
        prev_oe   = mdio_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            bus_read(1'b0, v);
            if (!v[31]) break;
        end
    endtask

    task automatic xact(input bit wr, input logic [4:0] phy, input logic [4:0] rn,
                        input logic [15:0] wval, input logic [15:0] rval,
                        input bit clash);
        logic [31:0] v;
        logic [45:0] hdr;
        if (wr) bus_write(1'b1, wval);
        phy_val = rval;
        pos     = 0;
        r8_viol = 0;
        bus_write(1'b0, {5'd0, wr, phy, rn});
        bus_read(1'b0, v);
        chk(v[31] == 1'b1, "R4 busy after launch", {32'd0, v}, 64'h8000_0000);
        if (clash) begin
            repeat (20) @(negedge clk);
            bus_write(1'b0, {5'd0, ~wr, ~phy, ~rn});
        end
        wait_idle();
        bus_read(1'b0, v);
        chk(v == {21'd0, wr, phy, rn}, clash ? "R9 command readback" : "R4 busy clear",
            {32'd0, v}, {53'd0, wr, phy, rn});
        hdr = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rn};
        chk(cap_bits[63:18] == hdr, wr ? "R3 write header" : (clash ? "R9 header" : "R2 read header"),
            {18'd0, cap_bits[63:18]}, {18'd0, hdr});
        chk(pos == 64, "R7 rising edges per frame", 64'(pos), 64'd64);
        chk(rise_dt == 20, "R7 MDC period", 64'(rise_dt), 64'd20);
        chk(r8_viol == 0, "R8 change while MDC high", 64'(r8_viol), 64'd0);
        bus_read(1'b1, v);
        if (wr) begin
            chk(cap_bits[17:0] == {2'b10, wval}, "R3 turnaround and data",
                {46'd0, cap_bits[17:0]}, {46'd0, 2'b10, wval});
            chk(cap_oe == '1, "R5 write enable", cap_oe, '1);
            chk(v == {16'd0, wval}, "R10 data kept", {32'd0, v}, {48'd0, wval});
        end else begin
            chk(cap_oe == {{46{1'b1}}, 18'd0}, "R5 read release", cap_oe, {{46{1'b1}}, 18'd0});
            chk(v == {16'd0, rval}, "R6 read capture", {32'd0, v}, {48'd0, rval});
        end
        repeat (20) @(negedge clk);
        chk(pos == 64 && !mdc, "R7 idle MDC low", 64'(pos), 64'd64);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bus_read(1'b0, v);
        chk(v == 32'd0, "R1 command reset", {32'd0, v}, 64'd0);
        bus_read(1'b1, v);
        chk(v == 32'd0, "R1 data reset", {32'd0, v}, 64'd0);
        chk(!mdc && !mdio_oe, "R1 lines idle", {62'd0, mdc, mdio_oe}, 64'd0);
        bus_write(1'b1, 16'hBEEF);
        bus_read(1'b1, v);
        chk(v == 32'h0000_BEEF, "R10 data write", {32'd0, v}, 64'h0000_BEEF);
        for (int p = 0; p < 32; p++) begin
            logic [15:0] rv;
            rv = 16'((p + 1) * 16'h1357) ^ {p[4:0], 11'h2A5};
            xact(1'b0, p[4:0], 5'(31 - p), 16'h0, rv, 1'b0);
            xact(1'b1, p[4:0], p[4:0], ~rv, 16'h0, 1'b0);
        end
        xact(1'b0, 5'd9, 5'd17, 16'h0, 16'h8001, 1'b1);
        xact(1'b1, 5'd22, 5'd5, 16'h7FFE, 16'h0, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #950000;
        if (!finished) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule